// File: doc/BRIEF.md
# Stop-Mode Wakeup Clock Switchover

This block decides which clock drives the core as it leaves a low-power stop state. Software sets a select input before stopping. If the select is set when stop is entered, the core restarts on the next control cycle from a fast but imprecise internal ring oscillator. Meanwhile the external source gets time to settle. A counter in the external-clock domain counts a fixed number of external cycles. When it finishes, the block moves the system clock back to the external source and drops a ring-mode status flag. If the select is clear at stop entry, the ring oscillator is not used: the core stays halted until the same count completes, then resumes on the external source.

While the ring-mode flag is high, the block forces the enable requests of timing-sensitive peripherals (network, CAN and serial controllers) to zero. It passes them through once the flag is low. The clock multiplexer is a behavioural model. The control logic runs on a free-running control clock. The terminal count crosses into that domain through a two-flop synchroniser.

Top module: `wake_switchover`

## Requirements
- R1: After reset, ringMode is 0, selRing is 0, coreRun is 1 and every periphEn bit equals its periphReq bit.
- R2: A stopEnter pulse while coreRun is 1 drives coreRun to 0 on the next control cycle and loads ringMode with the value ringSelect had in that cycle.
- R3: A stopExit pulse while stopped with ringMode 1 drives coreRun and selRing to 1 on the next control cycle, and ringMode stays 1. While selRing is 1, clkSys follows clkRing.
- R4: In ring mode, the switchover happens only after WAKE_COUNT rising edges of clkExt have been counted from the wake request (ring edges are not counted). At the switchover, ringMode and selRing fall together, coreRun stays 1 and clkSys follows clkExt. Seen from the stopExit cycle, this takes at least 4*(WAKE_COUNT-1) and at most 4*WAKE_COUNT+40 control cycles when clkExt runs at a quarter of clkCtl.
- R5: A stopExit with ringMode 0 keeps ringMode and selRing at 0 and keeps coreRun at 0 until the same count completes. coreRun then rises in the same cycle a ring window would have switched over.
- R6: For every peripheral bit i, periphEn[i] is 0 while ringMode is 1 and equals periphReq[i] while ringMode is 0.
- R7: If stopEnter falls in the same control cycle as a pending switchover, the stop entry wins: coreRun goes to 0, ringMode takes the select value, no switchover occurs, and the next window counts a full WAKE_COUNT again.
- R8: An rstN assertion during a wake window at once forces ringMode to 0, selRing to 0 and coreRun to 1.
- R9: stopExit has no effect while coreRun is 1, and stopEnter has no effect while stopped.
- R10: The counter restarts from zero for every window, so two windows started at the same clkExt phase switch over after the same number of control cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkCtl | input | 1 | Free-running control-domain clock |
| clkExt | input | 1 | External (crystal) clock source |
| clkRing | input | 1 | Ring-oscillator clock model |
| rstN | input | 1 | Asynchronous active-low reset |
| stopEnter | input | 1 | One-cycle request to enter stop |
| stopExit | input | 1 | One-cycle stop-exit event |
| ringSelect | input | 1 | Use the ring oscillator for the next wakeup |
| periphReq | input | NUM_PERIPH | Enable requests of timing-sensitive peripherals |
| clkSys | output | 1 | Behaviourally multiplexed system clock |
| selRing | output | 1 | Clock select, 1 = ring oscillator |
| ringMode | output | 1 | Ring-mode status flag, read-only |
| coreRun | output | 1 | Core may execute |
| periphEn | output | NUM_PERIPH | Qualified peripheral enables |

## Verification
The end of the count and a fresh stop entry can fall in the same control cycle. In that cycle the block must choose between switching to the external source and stopping again. The bench first measures the latency of a window started at a fixed clkExt phase. It then starts a window at the same phase and pulses stopEnter in the cycle where the switchover would take effect. The scoreboard treats any flag fall in that window as an unexpected switchover. The bench also checks that the block is stopped with the flag set, and that the next window takes the full measured latency.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic [1:0] {
    WK_RUN_EXT  = 2'd0,
    WK_STOPPED  = 2'd1,
    WK_RING_RUN = 2'd2,
    WK_WAIT_EXT = 2'd3
  } wakeState_e;

  typedef struct packed {
    logic countRun;     // ask the external domain to count
    logic flagLoad;     // load the ring-mode flag
    logic flagLoadVal;  // value for the load
    logic flagClear;    // switchover: clear the flag
    logic muxRing;      // select the ring clock
    logic coreRun;      // core allowed to execute
  } wakeStrobe_t;

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
(
  input  logic        clkCtl,
  input  logic        rstN,
  input  logic        stopEnter,
  input  logic        stopExit,
  input  logic        ringSelect,
  input  logic        ringMode,
  input  logic        extActive,
  input  logic        extDone,
  output wakeStrobe_t strobe
);
  wakeState_e state, nextState;
  logic armed, armedNext;
  logic counting;

  assign counting = (state == WK_RING_RUN) || (state == WK_WAIT_EXT);

  always_comb begin
    nextState          = state;
    strobe             = '0;
    strobe.coreRun     = (state == WK_RUN_EXT) || (state == WK_RING_RUN);
    strobe.muxRing     = (state == WK_RING_RUN);
    strobe.countRun    = armed && counting;
    case (state)
      WK_RUN_EXT: begin
        if (stopEnter) begin
          nextState          = WK_STOPPED;
          strobe.flagLoad    = 1'b1;
          strobe.flagLoadVal = ringSelect;
        end
      end
      WK_STOPPED: begin
        if (stopExit) nextState = ringMode ? WK_RING_RUN : WK_WAIT_EXT;
      end
      WK_RING_RUN: begin
        if (stopEnter) begin
          // a new stop entry outranks a switchover in the same cycle
          nextState          = WK_STOPPED;
          strobe.flagLoad    = 1'b1;
          strobe.flagLoadVal = ringSelect;
        end else if (armed && extDone) begin
          nextState        = WK_RUN_EXT;
          strobe.flagClear = 1'b1;
        end
      end
      WK_WAIT_EXT: begin
        if (armed && extDone) nextState = WK_RUN_EXT;
      end
      default: nextState = WK_RUN_EXT;
    endcase

    // arm the counter only once the external side reports idle,
    // so the count always starts from zero
    armedNext = 1'b0;
    if (counting && (nextState == state)) armedNext = armed || !extActive;
  end

  always_ff @(posedge clkCtl or negedge rstN) begin
    if (!rstN) begin
      state <= WK_RUN_EXT;
      armed <= 1'b0;
    end else begin
      state <= nextState;
      armed <= armedNext;
    end
  end
endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int WAKE_COUNT  = 65536,
  parameter int NUM_PERIPH  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clkCtl,
  input  logic                  clkExt,
  input  logic                  clkRing,
  input  logic                  rstN,
  input  wakeStrobe_t           strobe,
  input  logic [NUM_PERIPH-1:0] periphReq,
  output logic                  clkSys,
  output logic                  selRing,
  output logic                  ringMode,
  output logic [NUM_PERIPH-1:0] periphEn,
  output logic                  extActive,
  output logic                  extDone
);
  localparam int CNT_W = (WAKE_COUNT > 2) ? $clog2(WAKE_COUNT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_COUNT - 1);

  // ---------------- external-clock domain ----------------
  logic             runExt;
  logic [CNT_W-1:0] cycleCnt;
  logic             doneExt;
  logic             activeExt;

  wake_sync #(.STAGES(SYNC_STAGES)) uRunSync (
    .clk(clkExt), .rstN(rstN), .d(strobe.countRun), .q(runExt)
  );

  always_ff @(posedge clkExt or negedge rstN) begin
    if (!rstN) begin
      cycleCnt  <= '0;
      doneExt   <= 1'b0;
      activeExt <= 1'b0;
    end else if (!runExt) begin
      cycleCnt  <= '0;
      doneExt   <= 1'b0;
      activeExt <= 1'b0;
    end else begin
      activeExt <= 1'b1;
      if (!doneExt) begin
        cycleCnt <= cycleCnt + 1'b1;
        if (cycleCnt == LAST) doneExt <= 1'b1;
      end
    end
  end

  // ---------------- back into the control domain ----------------
  wake_sync #(.STAGES(SYNC_STAGES)) uDoneSync (
    .clk(clkCtl), .rstN(rstN), .d(doneExt), .q(extDone)
  );
  wake_sync #(.STAGES(SYNC_STAGES)) uActiveSync (
    .clk(clkCtl), .rstN(rstN), .d(activeExt), .q(extActive)
  );

  // ---------------- status flag ----------------
  always_ff @(posedge clkCtl or negedge rstN) begin
    if (!rstN)                 ringMode <= 1'b0;
    else if (strobe.flagLoad)  ringMode <= strobe.flagLoadVal;
    else if (strobe.flagClear) ringMode <= 1'b0;
  end

  // ---------------- behavioural clock mux ----------------
  assign selRing = strobe.muxRing;
  assign clkSys  = selRing ? clkRing : clkExt;

  // ---------------- peripheral qualification ----------------
  for (genvar i = 0; i < NUM_PERIPH; i++) begin : gQual
    assign periphEn[i] = periphReq[i] && !ringMode;
  end
endmodule

// File: rtl/wake_switchover.sv
module wake_switchover
  import wake_pkg::*;
#(
  parameter int WAKE_COUNT  = 65536,
  parameter int NUM_PERIPH  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clkCtl,
  input  logic                  clkExt,
  input  logic                  clkRing,
  input  logic                  rstN,
  input  logic                  stopEnter,
  input  logic                  stopExit,
  input  logic                  ringSelect,
  input  logic [NUM_PERIPH-1:0] periphReq,
  output logic                  clkSys,
  output logic                  selRing,
  output logic                  ringMode,
  output logic                  coreRun,
  output logic [NUM_PERIPH-1:0] periphEn
);
  wakeStrobe_t strobe;
  logic        extActive;
  logic        extDone;

  wake_ctrl uCtrl (
    .clkCtl    (clkCtl),
    .rstN      (rstN),
    .stopEnter (stopEnter),
    .stopExit  (stopExit),
    .ringSelect(ringSelect),
    .ringMode  (ringMode),
    .extActive (extActive),
    .extDone   (extDone),
    .strobe    (strobe)
  );

  wake_datapath #(
    .WAKE_COUNT (WAKE_COUNT),
    .NUM_PERIPH (NUM_PERIPH),
    .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clkCtl   (clkCtl),
    .clkExt   (clkExt),
    .clkRing  (clkRing),
    .rstN     (rstN),
    .strobe   (strobe),
    .periphReq(periphReq),
    .clkSys   (clkSys),
    .selRing  (selRing),
    .ringMode (ringMode),
    .periphEn (periphEn),
    .extActive(extActive),
    .extDone  (extDone)
  );

  assign coreRun = strobe.coreRun;
endmodule

// File: rtl/wake_switchover_chk.sv
module wake_switchover_chk #(
  parameter int NUM_PERIPH = 3
) (
  input logic                  clkCtl,
  input logic                  rstN,
  input logic                  stopEnter,
  input logic                  stopExit,
  input logic                  ringSelect,
  input logic [NUM_PERIPH-1:0] periphEn,
  input logic                  selRing,
  input logic                  ringMode,
  input logic                  coreRun
);
  // R3: the ring clock is only selected while the flag reports ring mode
  assert_ring_needs_flag_R3: assert property (@(posedge clkCtl) disable iff (!rstN)
    selRing |-> ringMode);

  // R3: a wake from a ring-mode stop resumes the core on the next cycle
  assert_fast_resume_R3: assert property (@(posedge clkCtl) disable iff (!rstN)
    (!coreRun && ringMode && stopExit) |=> (coreRun && selRing));

  // R2: stop entry halts the core and captures the select
  assert_stop_entry_R2: assert property (@(posedge clkCtl) disable iff (!rstN)
    (coreRun && stopEnter) |=> (!coreRun && (ringMode == $past(ringSelect))));

  // R4: when the flag falls, the ring clock is no longer selected
  assert_flag_fall_R4: assert property (@(posedge clkCtl) disable iff (!rstN)
    $fell(ringMode) |-> !selRing);

  // R5: waiting on the external source never selects the ring clock
  assert_wait_no_ring_R5: assert property (@(posedge clkCtl) disable iff (!rstN)
    (!coreRun && !ringMode) |-> !selRing);

  // R6: peripherals stay gated while in ring mode
  assert_gate_R6: assert property (@(posedge clkCtl) disable iff (!rstN)
    ringMode |-> (periphEn == '0));

  // R9: an exit pulse does not stop a running core
  assert_exit_ignored_R9: assert property (@(posedge clkCtl) disable iff (!rstN)
    (coreRun && stopExit && !stopEnter) |=> coreRun);
endmodule

bind wake_switchover wake_switchover_chk #(.NUM_PERIPH(NUM_PERIPH)) uChk (.*);

// File: tb/tb_wake_switchover.sv
`timescale 1ns/1ps
module tb_wake_switchover;
  localparam int N  = 40;
  localparam int NP = 3;

  logic clkCtl = 1'b0, clkExt = 1'b0, clkRing = 1'b0;
  logic rstN = 1'b0, stopEnter = 1'b0, stopExit = 1'b0, ringSelect = 1'b0;
  logic [NP-1:0] periphReq = '0;
  logic clkSys, selRing, ringMode, coreRun;
  logic [NP-1:0] periphEn;

  always #5  clkCtl  = ~clkCtl;   // 100 MHz
  always #20 clkExt  = ~clkExt;   // quarter rate
  always #33 clkRing = ~clkRing;

  wake_switchover #(.WAKE_COUNT(N), .NUM_PERIPH(NP)) dut (
    .clkCtl(clkCtl), .clkExt(clkExt), .clkRing(clkRing), .rstN(rstN),
    .stopEnter(stopEnter), .stopExit(stopExit), .ringSelect(ringSelect),
    .periphReq(periphReq), .clkSys(clkSys), .selRing(selRing),
    .ringMode(ringMode), .coreRun(coreRun), .periphEn(periphEn)
  );

  int checks = 0, errors = 0;
  int cyc = 0, exitCyc = 0, lastLat = -1;
  bit finished = 1'b0;

  typedef struct { int lo; int hi; string req; } expItem_t;
  expItem_t expQ[$];

  always @(posedge clkCtl) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chkEq(int act, int exp, string req, string what);
    chk(act == exp, req, what, act, exp);
  endtask

  // scoreboard monitor: every flag fall must match a queued expectation
  logic prevFlag = 1'b0;
  always @(negedge clkCtl) begin
    int lat;
    expItem_t e;
    if (rstN && prevFlag && !ringMode) begin
      lat = cyc - exitCyc;
      if (expQ.size() == 0) chk(1'b0, "R7", "unexpected switchover", lat, -1);
      else begin
        e = expQ.pop_front();
        chk(lat >= e.lo && lat <= e.hi, e.req, "switchover latency", lat, e.lo);
        lastLat = lat;
      end
    end
    prevFlag = ringMode;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clkCtl);
  endtask

  task automatic enterStop(bit sel);
    ringSelect = sel;
    stopEnter  = 1'b1;
    tick(1);
    stopEnter  = 1'b0;
  endtask

  task automatic pushExp(int lo, int hi, string req);
    expItem_t e;
    e.lo = lo; e.hi = hi; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic exitAligned();
    @(posedge clkExt);
    @(negedge clkCtl);
    exitCyc  = cyc;
    stopExit = 1'b1;
    tick(1);
    stopExit = 1'b0;
  endtask

  task automatic waitFlagLow(string req);
    int n = 0;
    while (ringMode && n < 400) begin tick(1); n++; end
    chk(!ringMode, req, "flag never cleared", int'(ringMode), 0);
  endtask

  task automatic clockSamples(bit wantRing, string req);
    for (int k = 0; k < 4; k++) begin
      #7;
      chkEq(int'(clkSys), wantRing ? int'(clkRing) : int'(clkExt), req, "clkSys source");
    end
    tick(1);
  endtask

  initial begin
    int lat1;
    int n;
    periphReq = 3'b101;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chkEq(int'(ringMode), 0, "R1", "ringMode");
    chkEq(int'(selRing), 0, "R1", "selRing");
    chkEq(int'(coreRun), 1, "R1", "coreRun");
    chkEq(int'(periphEn), 5, "R1", "periphEn");

    // R9 exit while running
    stopExit = 1'b1; tick(1); stopExit = 1'b0;
    chkEq(int'(coreRun), 1, "R9", "coreRun after stray exit");
    chkEq(int'(selRing), 0, "R9", "selRing after stray exit");
    tick(5);

    // ring window 1
    periphReq = 3'b111;
    enterStop(1'b1);
    chkEq(int'(coreRun), 0, "R2", "coreRun after entry");
    chkEq(int'(ringMode), 1, "R2", "ringMode after entry");
    chkEq(int'(periphEn), 0, "R6", "periphEn gated in stop");
    stopEnter = 1'b1; tick(1); stopEnter = 1'b0;
    chkEq(int'(coreRun), 0, "R9", "second entry while stopped");
    tick(20);
    pushExp(4 * (N - 1), 4 * N + 40, "R4");
    exitAligned();
    chkEq(int'(coreRun), 1, "R3", "coreRun on ring wake");
    chkEq(int'(selRing), 1, "R3", "selRing on ring wake");
    chkEq(int'(ringMode), 1, "R3", "ringMode on ring wake");
    clockSamples(1'b1, "R3");
    chkEq(int'(periphEn), 0, "R6", "periphEn gated in ring run");
    waitFlagLow("R4");
    chkEq(int'(selRing), 0, "R4", "selRing after switchover");
    chkEq(int'(coreRun), 1, "R4", "coreRun after switchover");
    clockSamples(1'b0, "R4");
    periphReq = 3'b010; #1;
    chkEq(int'(periphEn), 2, "R6", "periphEn pass pattern 010");
    periphReq = 3'b111; #1;
    chkEq(int'(periphEn), 7, "R6", "periphEn pass pattern 111");
    lat1 = lastLat;
    tick(30);

    // R10 repeat window at the same phase
    enterStop(1'b1);
    tick(20);
    pushExp(lat1, lat1, "R10");
    exitAligned();
    waitFlagLow("R10");
    tick(30);

    // R5 wakeup without the ring oscillator
    enterStop(1'b0);
    chkEq(int'(ringMode), 0, "R5", "flag after entry with select 0");
    tick(20);
    exitAligned();
    chkEq(int'(coreRun), 0, "R5", "core waits");
    chkEq(int'(selRing), 0, "R5", "selRing while waiting");
    chkEq(int'(ringMode), 0, "R5", "flag while waiting");
    n = 0;
    while (!coreRun && n < 400) begin tick(1); n++; end
    chkEq(cyc - exitCyc, lat1, "R5", "resume latency");
    tick(30);

    // R7 stop entry in the switchover cycle
    enterStop(1'b1);
    tick(20);
    exitAligned();
    tick(lat1 - 2);
    ringSelect = 1'b1;
    stopEnter  = 1'b1;
    tick(1);
    stopEnter  = 1'b0;
    chkEq(int'(coreRun), 0, "R7", "core halted after collision");
    chkEq(int'(ringMode), 1, "R7", "flag kept after collision");
    chkEq(int'(selRing), 0, "R7", "selRing after collision");
    tick(30);
    pushExp(lat1, lat1, "R7");
    exitAligned();
    waitFlagLow("R7");
    tick(30);

    // R8 reset inside a window
    enterStop(1'b1);
    tick(20);
    exitAligned();
    tick(50);
    rstN = 1'b0;
    #1;
    chkEq(int'(ringMode), 0, "R8", "flag on reset");
    chkEq(int'(selRing), 0, "R8", "selRing on reset");
    chkEq(int'(coreRun), 1, "R8", "coreRun on reset");
    tick(3);
    rstN = 1'b1;
    tick(5);

    chkEq(expQ.size(), 0, "R4", "expected switchovers left");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule